// File: doc/BRIEF.md
# Bulk Erase Algorithm Sequencer

This block is a host-side controller that runs the complete chip-erase procedure of a byte-wide flash through its command interface. A one-cycle `start` pulse begins a run. First a separate programming sequencer is asked, through a request/done handshake, to fill the whole array with 00h. The controller then issues bus cycles on a simple request/acknowledge master port. Each cycle is held until the flash side acknowledges it.

An erase pulse is two writes of 20h. A counter then times the pulse length for a parameterised number of clock ticks. After that the array is checked one byte at a time. Each check is a write of A0h carrying the byte address, followed by a read of that address.

When a byte fails, the whole chip is erased again, and checking resumes at the failing byte instead of at address 0. The run gives up after a fixed number of erase pulses. To end the run, the controller writes 00h to leave verify mode, then raises `done` or `fail`. The number of pulses used and the last failing address stay visible after the run.

Top module: `erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `pp_req` and `bus_req` are all low.
- R2: On `start`, `pp_req` rises and stays high until `pp_done` is seen. No bus cycle is issued before that point.
- R3: Every erase pulse is two consecutive write cycles with data 20h. `attempts` increases by one when the second write is acknowledged.
- R4: After the second 20h write is acknowledged, at least `PULSE_TICKS` clock cycles pass before the next verify command is acknowledged.
- R5: A byte check is a write of A0h with `bus_addr` set to the byte address, then a read cycle (`bus_we` low) of the same address. The byte passes only when the read returns FFh.
- R6: Checking starts at address 0. After a pass it moves to the next address, and it ends after the last address, 2^ADDR_W-1, passes.
- R7: When a byte fails and fewer than `MAX_PULSES` pulses have been used, a new erase pulse follows and checking resumes at the failing address. `fail_addr` holds the address that failed.
- R8: When a byte fails after `MAX_PULSES` pulses, no further pulse is issued and the run ends with `fail` high. `attempts` never exceeds `MAX_PULSES`.
- R9: A run ends with a write of 00h. After that write is acknowledged, `busy` falls and exactly one of `done` (all bytes passed) or `fail` is high. These flags hold until the next `start`.
- R10: While `bus_req` is high and not yet acknowledged, `bus_we`, `bus_addr` and `bus_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins an erase run |
| pp_req | output | 1 | Request to the pre-program (fill with 00h) sequencer |
| pp_done | input | 1 | Pre-program finished |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 8 | Command byte for write cycles |
| bus_ack | input | 1 | Bus cycle complete (one cycle) |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with every byte erased |
| fail | output | 1 | Run ended after the pulse limit |
| attempts | output | 10 | Erase pulses issued in this run |
| fail_addr | output | ADDR_W | Last address that failed a check |

## Verification
The bench builds the block with `ADDR_W` = 3, `PULSE_TICKS` = 5 and `MAX_PULSES` = 4. An 8-byte array then makes the last-address boundary and address wrap-up quick to reach. The short pulse timer lets the wait window be measured exactly. A limit of four pulses lets a stubborn byte drive the run into the give-up path within a few dozen bus cycles.

A behavioural flash model counts erase pulses and gives each byte its own number of pulses needed. This covers several cases: a clean single-pulse erase, a mid-array byte that forces re-erase and resumption, a last byte that fails, and a byte that can never be erased.

// File: rtl/erase_seq.sv
module erase_seq #(
  parameter int ADDR_W      = 18,
  parameter int PULSE_TICKS = 2000000,
  parameter int MAX_PULSES  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              pp_req,
  input  logic              pp_done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [9:0]        attempts,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int TW = $clog2(PULSE_TICKS + 1);
  localparam logic [TW-1:0]     T_LAST = TW'(PULSE_TICKS - 1);
  localparam logic [9:0]        P_MAX  = 10'(MAX_PULSES);
  localparam logic [ADDR_W-1:0] A_LAST = '1;

  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_SET, S_ERS, S_WAIT, S_VCMD, S_VRD, S_EXIT
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr;
  logic [TW-1:0]     timer;
  logic              give_up;

  assign pp_req   = (st == S_PREP);
  assign busy     = (st != S_IDLE);
  assign bus_req  = (st == S_SET) || (st == S_ERS) || (st == S_VCMD) ||
                    (st == S_VRD) || (st == S_EXIT);
  assign bus_we   = (st != S_VRD);
  assign bus_addr = addr;

  always_comb begin
    case (st)
      S_SET, S_ERS: bus_wdata = 8'h20;
      S_VCMD:       bus_wdata = 8'hA0;
      default:      bus_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr      <= '0;
      timer     <= '0;
      attempts  <= '0;
      fail_addr <= '0;
      give_up   <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done     <= 1'b0;
          fail     <= 1'b0;
          give_up  <= 1'b0;
          attempts <= '0;
          addr     <= '0;
          st       <= S_PREP;
        end
        S_PREP: if (pp_done) st <= S_SET;
        S_SET:  if (bus_ack) st <= S_ERS;
        S_ERS:  if (bus_ack) begin
          attempts <= attempts + 10'd1;
          timer    <= '0;
          st       <= S_WAIT;
        end
        S_WAIT: begin
          if (timer == T_LAST) st <= S_VCMD;
          else timer <= timer + 1'b1;
        end
        S_VCMD: if (bus_ack) st <= S_VRD;
        S_VRD:  if (bus_ack) begin
          if (bus_rdata == 8'hFF) begin
            if (addr == A_LAST) st <= S_EXIT;
            else begin
              addr <= addr + 1'b1;
              st   <= S_VCMD;
            end
          end else begin
            fail_addr <= addr;
            if (attempts >= P_MAX) begin
              give_up <= 1'b1;
              st      <= S_EXIT;
            end else st <= S_SET;
          end
        end
        S_EXIT: if (bus_ack) begin
          done <= !give_up;
          fail <= give_up;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_pp_no_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pp_req |-> !bus_req);
  assert_hold_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));
  assert_pulse_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= P_MAX);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  assert_idle_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);
  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> attempts >= $past(attempts));
endmodule

// File: tb/erase_seq_tb_top.sv
module erase_seq_tb_top;
  localparam int AW = 3;
  localparam int PT = 5;
  localparam int MP = 4;
  localparam int NB = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0, pp_done = 0, bus_ack = 0;
  logic [7:0] bus_rdata = 0;
  logic pp_req, bus_req, bus_we, busy, done, fail;
  logic [AW-1:0] bus_addr, fail_addr;
  logic [7:0] bus_wdata;
  logic [9:0] attempts;

  int errors = 0, checks = 0, cyc = 0;
  int need[NB];
  int pulses; bit last20;
  int ers_cyc;
  int q_we[$], q_dat[$], q_adr[$];
  string q_tag[$];
  bit exp_fail; int exp_att, exp_faddr;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  erase_seq #(.ADDR_W(AW), .PULSE_TICKS(PT), .MAX_PULSES(MP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pp_req(pp_req), .pp_done(pp_done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .done(done), .fail(fail),
    .attempts(attempts), .fail_addr(fail_addr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int we, input int dat, input int adr, input string tag);
    q_we.push_back(we); q_dat.push_back(dat); q_adr.push_back(adr); q_tag.push_back(tag);
  endtask

  task automatic build();
    int p, a;
    p = 1; a = 0; exp_faddr = -1;
    push(1, 'h20, -1, "R3"); push(1, 'h20, -1, "R3");
    forever begin
      push(1, 'hA0, a, "R6"); push(0, -1, a, "R5");
      if (p >= need[a]) begin
        if (a == NB - 1) begin push(1, 'h00, -1, "R9"); exp_fail = 0; break; end
        a++;
      end else begin
        exp_faddr = a;
        if (p == MP) begin push(1, 'h00, -1, "R8"); exp_fail = 1; break; end
        push(1, 'h20, -1, "R7"); push(1, 'h20, -1, "R7"); p++;
      end
    end
    exp_att = p;
  endtask

  task automatic run(input string name);
    int w; bit seen_bus;
    pulses = 0; last20 = 0; seen_bus = 0;
    build();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk(pp_req === 1'b1, "R2 pp_req", pp_req, 1);
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (bus_req) seen_bus = 1; end
    chk(!seen_bus, "R2 no bus before pp_done", seen_bus, 0);
    pp_done = 1; @(negedge clk); pp_done = 0;
    w = 0;
    while (busy && w < 5000) begin
      @(negedge clk); w++;
      if (bus_req && !bus_ack) begin
        bus_ack = 1;
        if (q_we.size() == 0) chk(0, "R9 unexpected bus cycle", bus_wdata, 0);
        else begin
          int ew, ed, ea; string t;
          ew = q_we.pop_front(); ed = q_dat.pop_front(); ea = q_adr.pop_front(); t = q_tag.pop_front();
          chk(bus_we == ew, {t, " we"}, bus_we, ew);
          if (ed >= 0) chk(bus_wdata == ed, {t, " data"}, bus_wdata, ed);
          if (ea >= 0) chk(bus_addr == ea, {t, " addr"}, bus_addr, ea);
          if (bus_we && bus_wdata == 8'hA0 && last20 == 0 && ers_cyc >= 0) begin
            chk(cyc - ers_cyc > PT, "R4 pulse wait", cyc - ers_cyc, PT + 1);
            ers_cyc = -1;
          end
          if (bus_we && bus_wdata == 8'h20) begin
            if (last20) begin pulses++; last20 = 0; ers_cyc = cyc; end else last20 = 1;
          end else last20 = 0;
          bus_rdata = (pulses >= need[bus_addr]) ? 8'hFF : 8'h00;
        end
      end else bus_ack = 0;
    end
    @(negedge clk);
    chk(!busy, {"R9 busy low ", name}, busy, 0);
    chk(done == !exp_fail && fail == exp_fail, {"R9/R8 outcome ", name}, {done, fail}, {!exp_fail, exp_fail});
    chk(attempts == exp_att, {"R3 attempts ", name}, attempts, exp_att);
    if (exp_faddr >= 0) chk(fail_addr == exp_faddr, {"R7 fail_addr ", name}, fail_addr, exp_faddr);
    chk(q_we.size() == 0, {"R6 sequence complete ", name}, q_we.size(), 0);
    q_we.delete(); q_dat.delete(); q_adr.delete(); q_tag.delete();
  endtask

  initial begin
    ers_cyc = -1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !pp_req && !bus_req, "R1 reset state",
        {busy, done, fail, pp_req, bus_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_req, "R1 idle after reset", {busy, bus_req}, 0);
    foreach (need[i]) need[i] = 1;
    run("clean");
    foreach (need[i]) need[i] = 1; need[5] = 3;
    run("resume mid");
    foreach (need[i]) need[i] = 1; need[NB-1] = 2; need[0] = 2;
    run("first and last");
    foreach (need[i]) need[i] = 1; need[2] = 9;
    run("give up");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule